// File: doc/BRIEF.md
# Cartridge Bank-Switching Register Decoder

This block is the address-mapping front end of a game cartridge that sits on an 8-bit CPU bus with a 16-bit address. CPU writes to the upper half of the address space are decoded through a partial address mask. Three registers can be written: a graphics (pattern) bank select, a program bank select for the window at $6000-$7FFF, and a nametable layout select. From these registers and the current CPU and video-side addresses, the block forms the byte addresses that go to the program ROM and to the pattern memory. It also forms the mirroring flag that the nametable logic uses.

The whole of $8000-$FFFF is wired to the last four 8 KiB program banks. Only the low window can be switched. The program and pattern bank counts are parameters, and they need not be powers of two. A parameter also selects whether the pattern memory is a banked ROM or a single 8 KiB writable RAM. Register state updates on the clock edge of the write. The address outputs are combinational from the registers and the incoming addresses.

Top module: `cart_bank_map`

## Requirements
- R1: After reset, the program bank and the pattern bank are both 0. The nametable flag follows `mirror_cfg` until the first layout write.
- R2: A write is decoded from `cpu_wr_addr & $E003`. The value $8000 loads the pattern bank, $E000 loads the program bank and $E001 loads the layout. Every other value, including $E002, $E003, $A001 and $C000, changes nothing that can be seen at the outputs.
- R3: The bank registers keep only data bits 3:0. The upper nibble is dropped, so writing $F3 selects bank 3.
- R4: For a CPU read address in $6000-$7FFF, `prg_hit` is 1 and `prg_rom_addr` = (selected program bank) * 8192 + address bits 12:0.
- R5: For a read address in $8000-$FFFF, `prg_rom_addr` = (PRG_BANKS - 4 + address bits 14:13) * 8192 + address bits 12:0. With 11 banks, the four 8 KiB slots map to banks 7, 8, 9 and 10.
- R6: The program bank select is reduced modulo PRG_BANKS before it forms the address. The pattern select is reduced modulo CHR_BANKS in the same way. With 11 banks, selecting 13 maps to bank 2.
- R7: When pattern ROM is present, `chr_addr` = (pattern bank) * 8192 + `ppu_addr` bits 12:0, and `chr_ram_we` stays 0. Without ROM, `chr_addr` = `ppu_addr` bits 12:0 with the upper bits 0, the bank register has no effect, and `chr_ram_we` = `ppu_wr` while `ppu_addr` bit 13 is 0.
- R8: A layout write sets `mirror_horiz` to data bit 3 (0 vertical, 1 horizontal). From then on, `mirror_cfg` has no effect until reset.
- R9: A register write acts on the clock edge where `cpu_wr_en` is sampled high. Reads in the cycle before that edge still see the old mapping, and reads in the cycle after it see the new one.
- R10: For a read address below $6000, `prg_hit` is 0 and `prg_rom_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | CPU write strobe, one cycle per write |
| cpu_wr_addr | input | 16 | CPU write address |
| cpu_wr_data | input | 8 | CPU write data |
| cpu_rd_addr | input | 16 | CPU read address to be translated |
| prg_hit | output | 1 | Read address falls in $6000-$FFFF |
| prg_rom_addr | output | clog2(PRG_BANKS)+13 | Program ROM byte address |
| ppu_addr | input | 14 | Video-side address |
| ppu_wr | input | 1 | Video-side write strobe |
| chr_addr | output | clog2(CHR_BANKS)+13 | Pattern memory byte address |
| chr_ram_we | output | 1 | Write enable for pattern RAM (RAM variant only) |
| mirror_cfg | input | 1 | Layout used before the first layout write (1 horizontal) |
| mirror_horiz | output | 1 | Current nametable layout, 1 horizontal |

## Verification
The bench aims at three groups of corner cases.

- **Aliased decode.** Writes to $9FFC and $FFFC alias onto the pattern and program registers, while writes to $E002 and $A001 must change nothing. A decoder that compares the full address would miss the aliases, and a decoder with too loose a mask would let those writes corrupt a bank.
- **Non-power-of-two bank count.** A second instance with 11 program banks catches fixed banks taken from the top of a power-of-two space, which give 12 to 15 instead of 7 to 10. It also catches a window select that is not reduced, which would point at memory that does not exist.
- **Write timing and layout source.** The bench samples the output in the cycle before and the cycle after the write edge, which exposes a mapping that lags by one cycle or reacts combinationally to the write bus. It toggles `mirror_cfg` after a layout write, which exposes a flag that keeps following the configuration input.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
   localparam int SEL_W   = 4;
   localparam int PAGE_W  = 13;
   localparam int MIR_BIT = 3;
   localparam logic [15:0] DEC_MASK = 16'hE003;
   localparam logic [15:0] ADR_CHR  = 16'h8000;
   localparam logic [15:0] ADR_PRG  = 16'hE000;
   localparam logic [15:0] ADR_MIR  = 16'hE001;

   typedef enum logic [1:0] {RK_NONE, RK_CHR, RK_PRG, RK_MIR} reg_kind_t;

   function automatic reg_kind_t decode_reg(input logic [15:0] a);
      logic [15:0] m;
      m = a & DEC_MASK;
      if (m == ADR_CHR)      return RK_CHR;
      else if (m == ADR_PRG) return RK_PRG;
      else if (m == ADR_MIR) return RK_MIR;
      else                   return RK_NONE;
   endfunction
endpackage

// File: rtl/cbm_regs.sv
module cbm_regs
   import cbm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [15:0]      wr_addr,
   input  logic [7:0]       wr_data,
   output logic [SEL_W-1:0] chr_sel,
   output logic [SEL_W-1:0] prg_sel,
   output logic             mir_valid,
   output logic             mir_horiz
);
   reg_kind_t kind;
   wire unused_hi_data = ^wr_data[7:SEL_W];

   always_comb kind = wr_en ? decode_reg(wr_addr) : RK_NONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chr_sel   <= '0;
         prg_sel   <= '0;
         mir_valid <= 1'b0;
         mir_horiz <= 1'b0;
      end else begin
         case (kind)
            RK_CHR: chr_sel <= wr_data[SEL_W-1:0];
            RK_PRG: prg_sel <= wr_data[SEL_W-1:0];
            RK_MIR: begin
               mir_valid <= 1'b1;
               mir_horiz <= wr_data[MIR_BIT];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map
   import cbm_pkg::*;
#(
   parameter int BANKS = 16,
   localparam int IDX_W = $clog2(BANKS),
   localparam int AW    = IDX_W + PAGE_W
) (
   input  logic [SEL_W-1:0] prg_sel,
   input  logic [15:0]      rd_addr,
   output logic             hit,
   output logic [AW-1:0]    rom_addr
);
   localparam bit POW2 = (BANKS & (BANKS - 1)) == 0;
   localparam logic [IDX_W-1:0] FIX_BASE = IDX_W'(BANKS - 4);

   logic [IDX_W-1:0] win_idx;
   logic [IDX_W-1:0] idx;

   generate
      if (POW2) begin : g_pow2
         assign win_idx = IDX_W'(prg_sel);
      end else begin : g_mod
         assign win_idx = IDX_W'(32'(prg_sel) % 32'(BANKS));
      end
   endgenerate

   always_comb begin
      hit = 1'b1;
      idx = '0;
      if (rd_addr[15:13] < 3'd3)
         hit = 1'b0;
      else if (rd_addr[15:13] == 3'd3)
         idx = win_idx;
      else
         idx = FIX_BASE + IDX_W'(rd_addr[14:13]);
   end

   assign rom_addr = hit ? {idx, rd_addr[PAGE_W-1:0]} : '0;
endmodule

// File: rtl/cbm_chr_map.sv
module cbm_chr_map
   import cbm_pkg::*;
#(
   parameter int BANKS   = 16,
   parameter bit HAS_ROM = 1'b1,
   localparam int IDX_W  = $clog2(BANKS),
   localparam int AW     = IDX_W + PAGE_W
) (
   input  logic [SEL_W-1:0] chr_sel,
   input  logic [13:0]      ppu_addr,
   input  logic             ppu_wr,
   output logic [AW-1:0]    chr_addr,
   output logic             ram_we
);
   localparam bit POW2 = (BANKS & (BANKS - 1)) == 0;

   generate
      if (HAS_ROM) begin : g_rom
         logic [IDX_W-1:0] idx;
         wire unused_rom_in = ^{ppu_addr[13], ppu_wr};
         if (POW2) begin : g_pow2
            assign idx = IDX_W'(chr_sel);
         end else begin : g_mod
            assign idx = IDX_W'(32'(chr_sel) % 32'(BANKS));
         end
         assign chr_addr = {idx, ppu_addr[PAGE_W-1:0]};
         assign ram_we   = 1'b0;
      end else begin : g_ram
         wire unused_ram_sel = ^chr_sel;
         assign chr_addr = AW'(ppu_addr[PAGE_W-1:0]);
         assign ram_we   = ppu_wr & ~ppu_addr[13];
      end
   endgenerate
endmodule

// File: rtl/cart_bank_map.sv
module cart_bank_map
   import cbm_pkg::*;
#(
   parameter int PRG_BANKS   = 16,
   parameter int CHR_BANKS   = 16,
   parameter bit HAS_CHR_ROM = 1'b1,
   localparam int PRG_AW     = $clog2(PRG_BANKS) + PAGE_W,
   localparam int CHR_AW     = $clog2(CHR_BANKS) + PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr_en,
   input  logic [15:0]       cpu_wr_addr,
   input  logic [7:0]        cpu_wr_data,
   input  logic [15:0]       cpu_rd_addr,
   output logic              prg_hit,
   output logic [PRG_AW-1:0] prg_rom_addr,
   input  logic [13:0]       ppu_addr,
   input  logic              ppu_wr,
   output logic [CHR_AW-1:0] chr_addr,
   output logic              chr_ram_we,
   input  logic              mirror_cfg,
   output logic              mirror_horiz
);
   generate
      if (PRG_BANKS < 4) begin : g_bad_prg
         $error("PRG_BANKS must be at least 4");
      end
      if (CHR_BANKS < 2) begin : g_bad_chr
         $error("CHR_BANKS must be at least 2");
      end
   endgenerate

   logic [SEL_W-1:0] chr_sel, prg_sel;
   logic             mir_valid, mir_reg;

   cbm_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cpu_wr_en),
      .wr_addr   (cpu_wr_addr),
      .wr_data   (cpu_wr_data),
      .chr_sel   (chr_sel),
      .prg_sel   (prg_sel),
      .mir_valid (mir_valid),
      .mir_horiz (mir_reg)
   );

   cbm_prg_map #(.BANKS(PRG_BANKS)) u_prg (
      .prg_sel  (prg_sel),
      .rd_addr  (cpu_rd_addr),
      .hit      (prg_hit),
      .rom_addr (prg_rom_addr)
   );

   cbm_chr_map #(.BANKS(CHR_BANKS), .HAS_ROM(HAS_CHR_ROM)) u_chr (
      .chr_sel  (chr_sel),
      .ppu_addr (ppu_addr),
      .ppu_wr   (ppu_wr),
      .chr_addr (chr_addr),
      .ram_we   (chr_ram_we)
   );

   assign mirror_horiz = mir_valid ? mir_reg : mirror_cfg;
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
   parameter int PRG_BANKS   = 16,
   parameter int CHR_BANKS   = 16,
   parameter bit HAS_CHR_ROM = 1'b1
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            cpu_wr_en,
   input logic [15:0]                     cpu_wr_addr,
   input logic [3:0]                      wr_lo,
   input logic [15:0]                     cpu_rd_addr,
   input logic                            prg_hit,
   input logic [$clog2(PRG_BANKS)+12:0]   prg_rom_addr,
   input logic                            ppu_hi,
   input logic                            ppu_wr,
   input logic [$clog2(CHR_BANKS)+12:0]   chr_addr,
   input logic                            chr_ram_we,
   input logic                            mirror_horiz
);
   localparam int PRG_AW = $clog2(PRG_BANKS) + 13;
   localparam int CHR_AW = $clog2(CHR_BANKS) + 13;

   logic wr_prg, wr_chr, wr_mir, in_win;
   assign wr_prg = cpu_wr_en && ((cpu_wr_addr & 16'hE003) == 16'hE000);
   assign wr_chr = cpu_wr_en && ((cpu_wr_addr & 16'hE003) == 16'h8000);
   assign wr_mir = cpu_wr_en && ((cpu_wr_addr & 16'hE003) == 16'hE001);
   assign in_win = cpu_rd_addr[15:13] == 3'b011;

   AST_PRG_UPDATE: assert property (@(posedge clk) disable iff (!rst_n) // R9
      wr_prg |=> (!in_win || int'(prg_rom_addr[PRG_AW-1:13]) == int'($past(wr_lo)) % PRG_BANKS));

   AST_PRG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R2
      (in_win && !wr_prg) |=> (!in_win || $stable(prg_rom_addr[PRG_AW-1:13])));

   AST_FIXED_BANK: assert property (@(posedge clk) disable iff (!rst_n) // R5
      cpu_rd_addr[15] |-> (prg_hit && int'(prg_rom_addr[PRG_AW-1:13]) == PRG_BANKS - 4 + int'(cpu_rd_addr[14:13])));

   AST_LOW_MISS: assert property (@(posedge clk) disable iff (!rst_n) // R10
      (cpu_rd_addr[15:13] < 3'd3) |-> (!prg_hit && prg_rom_addr == '0));

   AST_MIR_UPDATE: assert property (@(posedge clk) disable iff (!rst_n) // R8
      wr_mir |=> (mirror_horiz == $past(wr_lo[3])));

   AST_RAM_WE: assert property (@(posedge clk) disable iff (!rst_n) // R7
      chr_ram_we |-> (ppu_wr && !ppu_hi));

   generate
      if (HAS_CHR_ROM) begin : g_rom
         AST_CHR_UPDATE: assert property (@(posedge clk) disable iff (!rst_n) // R7
            wr_chr |=> (int'(chr_addr[CHR_AW-1:13]) == int'($past(wr_lo)) % CHR_BANKS));
      end else begin : g_ram
         AST_CHR_FLAT: assert property (@(posedge clk) disable iff (!rst_n) // R7
            wr_chr |=> (chr_addr[CHR_AW-1:13] == '0));
      end
   endgenerate
endmodule

bind cart_bank_map cbm_checker #(
   .PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS), .HAS_CHR_ROM(HAS_CHR_ROM)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_wr_en    (cpu_wr_en),
   .cpu_wr_addr  (cpu_wr_addr),
   .wr_lo        (cpu_wr_data[3:0]),
   .cpu_rd_addr  (cpu_rd_addr),
   .prg_hit      (prg_hit),
   .prg_rom_addr (prg_rom_addr),
   .ppu_hi       (ppu_addr[13]),
   .ppu_wr       (ppu_wr),
   .chr_addr     (chr_addr),
   .chr_ram_we   (chr_ram_we),
   .mirror_horiz (mirror_horiz)
);

// File: tb/sim_cart_bank_map.sv
`timescale 1ns/1ps
module sim_cart_bank_map;
   localparam int B0 = 16;
   localparam int B1 = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [15:0] rd_addr = '0;
   logic [13:0] ppu_addr = '0;
   logic ppu_wr = 1'b0;
   logic cfg = 1'b1;

   logic        hit0, hit1, we0, we1, mir0, mir1;
   logic [16:0] pa0, pa1, ca0, ca1;

   always #2.5 clk = ~clk;

   cart_bank_map u0 (
      .clk(clk), .rst_n(rst_n), .cpu_wr_en(wr_en), .cpu_wr_addr(wr_addr),
      .cpu_wr_data(wr_data), .cpu_rd_addr(rd_addr), .prg_hit(hit0),
      .prg_rom_addr(pa0), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
      .chr_addr(ca0), .chr_ram_we(we0), .mirror_cfg(cfg), .mirror_horiz(mir0));

   cart_bank_map #(.PRG_BANKS(B1), .CHR_BANKS(B1), .HAS_CHR_ROM(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .cpu_wr_en(wr_en), .cpu_wr_addr(wr_addr),
      .cpu_wr_data(wr_data), .cpu_rd_addr(rd_addr), .prg_hit(hit1),
      .prg_rom_addr(pa1), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
      .chr_addr(ca1), .chr_ram_we(we1), .mirror_cfg(cfg), .mirror_horiz(mir1));

   int checks = 0;
   int failures = 0;
   bit done = 0;
   int m_prg = 0, m_chr = 0;
   bit m_mset = 0, m_mir = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_prg(input int banks, input logic [15:0] a);
      if (a[15:13] < 3'd3) return 0;
      if (a[15:13] == 3'd3) return (m_prg % banks) * 8192 + int'(a[12:0]);
      return (banks - 4 + int'(a[14:13])) * 8192 + int'(a[12:0]);
   endfunction

   function automatic int exp_chr0(input logic [13:0] p);
      return (m_chr % B0) * 8192 + int'(p[12:0]);
   endfunction

   function automatic void model_write(input logic [15:0] a, input logic [7:0] d);
      case (a & 16'hE003)
         16'h8000: m_chr = int'(d[3:0]);
         16'hE000: m_prg = int'(d[3:0]);
         16'hE001: begin m_mset = 1; m_mir = d[3]; end
         default: ;
      endcase
   endfunction

   task automatic do_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic probe(input string req, input logic [15:0] ra, input logic [13:0] pp);
      rd_addr = ra; ppu_addr = pp;
      #1;
      chk(req, "u0 prg_rom_addr", int'(pa0), exp_prg(B0, ra));
      chk(req, "u1 prg_rom_addr", int'(pa1), exp_prg(B1, ra));
      chk(req, "u0 prg_hit", int'(hit0), int'(ra[15:13] >= 3'd3));
      chk(req, "u0 chr_addr", int'(ca0), exp_chr0(pp));
      chk(req, "u1 chr_addr", int'(ca1), int'(pp[12:0]));
      chk(req, "u0 chr_ram_we", int'(we0), 0);
      chk(req, "u1 chr_ram_we", int'(we1), int'(ppu_wr && !pp[13]));
      chk(req, "u0 mirror", int'(mir0), int'(m_mset ? m_mir : cfg));
      chk(req, "u1 mirror", int'(mir1), int'(m_mset ? m_mir : cfg));
   endtask

   initial begin
      #900000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int unsigned seed_v;
      logic [15:0] wa_list [10];
      seed_v = $urandom(32'd4242);
      wa_list = '{16'h8000, 16'h9FFC, 16'hE000, 16'hFFFC, 16'hE001,
                  16'hE002, 16'hE003, 16'hA001, 16'hC000, 16'h6000};
      repeat (3) @(negedge clk);
      // R1: reset state, layout from configuration input
      probe("R1", 16'h6123, 14'h0456);
      cfg = 1'b0;
      probe("R1", 16'h7FFF, 14'h1FFF);
      rst_n = 1'b1;
      @(negedge clk);
      probe("R1", 16'h6000, 14'h0000);

      // R3: upper nibble dropped; R4 window both ends
      do_write(16'hE000, 8'hF3);
      probe("R3", 16'h6000, 14'h0010);
      probe("R4", 16'h7FFF, 14'h0010);
      do_write(16'h8000, 8'hF5);
      probe("R3", 16'h6800, 14'h0ABC);

      // R2: aliased and ignored addresses
      do_write(16'hFFFC, 8'h06);
      probe("R2", 16'h6001, 14'h0001);
      do_write(16'h9FFC, 8'h0A);
      probe("R2", 16'h6001, 14'h1234);
      do_write(16'hE002, 8'hFF);
      do_write(16'hE003, 8'hFF);
      do_write(16'hA001, 8'hFF);
      do_write(16'hC000, 8'hFF);
      probe("R2", 16'h6002, 14'h0002);

      // R8: layout register, then cfg has no effect
      do_write(16'hE001, 8'h08);
      probe("R8", 16'h6000, 14'h0000);
      cfg = 1'b0;
      probe("R8", 16'h6000, 14'h0000);
      do_write(16'hE001, 8'hF7);
      cfg = 1'b1;
      probe("R8", 16'h6000, 14'h0000);

      // R5: fixed banks, including non-power-of-two count
      probe("R5", 16'h8000, 14'h0000);
      probe("R5", 16'hA000, 14'h0000);
      probe("R5", 16'hC000, 14'h0000);
      probe("R5", 16'hE000, 14'h0000);
      probe("R5", 16'hFFFF, 14'h0000);

      // R6: modulo reduction
      do_write(16'hE000, 8'h0D);
      probe("R6", 16'h6000, 14'h0000);
      chk("R6", "u1 bank for select 13", int'(pa1) / 8192, 2);
      do_write(16'h8000, 8'h0C);
      probe("R6", 16'h6000, 14'h0777);

      // R9: write edge timing
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 16'hE000; wr_data = 8'h09; rd_addr = 16'h6000;
      #1;
      chk("R9", "u0 bank before edge", int'(pa0) / 8192, 13);
      @(negedge clk);
      wr_en = 1'b0;
      model_write(16'hE000, 8'h09);
      #1;
      chk("R9", "u0 bank after edge", int'(pa0) / 8192, 9);

      // R10: reads below the window
      probe("R10", 16'h4020, 14'h0000);
      probe("R10", 16'h5FFF, 14'h0000);

      // R7: pattern RAM write enable
      ppu_wr = 1'b1;
      probe("R7", 16'h6000, 14'h0100);
      probe("R7", 16'h6000, 14'h2100);
      ppu_wr = 1'b0;
      probe("R7", 16'h6000, 14'h0100);

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a;
         a = ($urandom % 4 == 0) ? 16'($urandom) : wa_list[$urandom % 10];
         do_write(a, 8'($urandom));
         cfg = 1'($urandom);
         ppu_wr = 1'($urandom);
         probe("R4", 16'($urandom), 14'($urandom));
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule